// File: doc/BRIEF.md
# Flash Command Sequencer with Erase Suspend

This block decodes the command bytes that a host writes to a parallel NOR-style flash and steps a state machine through erase, program, suspend and resume. It keeps a pair of protection bits for every block, lock and lock-down, and reports progress and errors in an 8-bit status word. Erase and program are abstract timed operations: each takes a fixed number of clock cycles and touches no array.

Each command is a byte with a block number. It arrives on a valid/ready stream. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` drops only while a suspend request is still settling. During that time the host must hold the byte and the block number steady. All other commands are accepted at once. A command that has no meaning in the current state is dropped without effect.

While an erase is suspended, the host may change block protection, read protection bits and status, and program other blocks. The error bits are sticky. A bad lock confirm or a failed program during the suspension stays visible after the erase resumes and after it finishes, and so masks the result of that erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status word is 0x80, `cmd_ready` is 1, and every block reads lock=1, down=0. `rd_lock` bit 0 is lock and bit 1 is down.
- R2: Byte 0x20 followed by 0xD0 on an unlocked block starts an erase. Status bit 7 (ready) is low for exactly ERS_CYC cycles after the confirm is accepted, and then high.
- R3: Byte 0xB0 during an erase keeps status bit 7 and `cmd_ready` low for SUS_LAT cycles. After that, bit 7 and bit 6 (erase suspended) read 1.
- R4: Byte 0x60 followed by 0x01 locks the addressed block. 0x60 followed by 0xD0 unlocks it. 0x60 followed by 0x2F sets both lock and down.
- R5: Byte 0x60 followed by any other byte sets status bits 5 and 4 and leaves the lock bits unchanged.
- R6: Error bits 5, 4 and 1 stay set through resume and through erase completion.
- R7: Locking the block whose erase is suspended takes effect at once. After 0xD0 resume, that erase still runs to completion.
- R8: While an erase is suspended, 0x40 plus a data byte programs another block. A program aimed at a locked block sets bits 4 and 1. A program aimed at the suspended block sets bit 4.
- R9: Byte 0x50, accepted while the block is ready, clears bits 5, 4 and 1.
- R10: An unlock on a block that is down has no effect until reset.
- R11: An erase confirm on a locked block starts no erase and sets bits 5 and 1. The block stays ready.
- R12: While a program is suspended (status bit 2 = 1), 0x60 and its confirm are ignored. 0xD0 resumes the program.
- R13: `cmd_ready` is low only while a suspend is pending. A command held during that time is accepted once, after the suspension completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_data | input | 8 | Command or data byte |
| cmd_blk | input | BLK_W | Block addressed by the command |
| status | output | 8 | Status word: 7 ready, 6 erase suspended, 5 erase/sequence error, 4 program/sequence error, 2 program suspended, 1 lock error |
| rd_blk | input | BLK_W | Block whose protection bits are read |
| rd_lock | output | 2 | {down, lock} of `rd_blk` |

## Verification
The hardest state to reach is an error made inside a suspended erase that is then carried past the resume. The erase must be running, the suspend latency must elapse, a nested lock sequence or program must fail, and the erase must then finish with its saved count. The vector table reaches this state by chaining those commands. The bench waits on back-pressure and on the ready bit, so each step lands in the intended state. A nested program suspend exercises the rejected lock path.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_LKSETUP = 8'h60;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_CLRSR   = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h01;
  localparam logic [7:0] OP_LOCKDN  = 8'h2F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ERS_SET, ST_PRG_SET, ST_LCK_SET,
    ST_ERASE, ST_PROG, ST_SWAIT, ST_ESUSP, ST_PSUSP
  } st_e;

  typedef enum logic [1:0] {LK_NONE, LK_LOCK, LK_UNLOCK, LK_DOWN} lkop_e;
endpackage

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == W'(1));
endmodule

// File: rtl/fcmd_lockbits.sv
module fcmd_lockbits
  import fcmd_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lkop_e            op,
  input  logic [BLK_W-1:0] op_blk,
  output logic [NBLK-1:0]  lk_on,
  output logic [NBLK-1:0]  lk_dn
);
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_on[g] <= 1'b1;
        lk_dn[g] <= 1'b0;
      end else if (op_blk == BLK_W'(g)) begin
        case (op)
          LK_LOCK:   lk_on[g] <= 1'b1;
          LK_DOWN:   begin lk_on[g] <= 1'b1; lk_dn[g] <= 1'b1; end
          LK_UNLOCK: if (!lk_dn[g]) lk_on[g] <= 1'b0;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int NBLK    = 8,
  parameter int ERS_CYC = 20,
  parameter int PRG_CYC = 6,
  parameter int SUS_LAT = 3,
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CNT_W  = $clog2(ERS_CYC + PRG_CYC + SUS_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  input  logic [BLK_W-1:0] cmd_blk,
  output logic [7:0]       status,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [1:0]       rd_lock
);
  st_e st, st_n;
  logic ers_act, prg_act, ers_sus, prg_sus;
  logic err_e, err_p, err_l;
  logic [BLK_W-1:0] ers_blk;
  logic [NBLK-1:0] lk_on, lk_dn;
  logic fire, cur_on, ready;
  logic ers_ld, prg_ld, sus_ld, ers_done, prg_done, sus_done;
  logic set_e, set_p, set_l, clr_err;
  lkop_e lkop;

  assign fire      = cmd_valid && cmd_ready;
  assign cmd_ready = (st != ST_SWAIT);
  assign cur_on    = lk_on[cmd_blk];
  assign rd_lock   = {lk_dn[rd_blk], lk_on[rd_blk]};
  assign ready     = !(st == ST_ERASE || st == ST_PROG || st == ST_SWAIT);
  assign status    = {ready, ers_sus, err_e, err_p, 1'b0, prg_sus, err_l, 1'b0};

  fcmd_lockbits #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .op(lkop), .op_blk(cmd_blk),
    .lk_on(lk_on), .lk_dn(lk_dn));

  fcmd_timer #(.W(CNT_W)) u_ers_t (
    .clk(clk), .rst_n(rst_n), .load(ers_ld), .val(CNT_W'(ERS_CYC)),
    .run(st == ST_ERASE), .done(ers_done));
  fcmd_timer #(.W(CNT_W)) u_prg_t (
    .clk(clk), .rst_n(rst_n), .load(prg_ld), .val(CNT_W'(PRG_CYC)),
    .run(st == ST_PROG), .done(prg_done));
  fcmd_timer #(.W(CNT_W)) u_sus_t (
    .clk(clk), .rst_n(rst_n), .load(sus_ld), .val(CNT_W'(SUS_LAT)),
    .run(st == ST_SWAIT), .done(sus_done));

  always_comb begin
    st_n = st; lkop = LK_NONE;
    ers_ld = 1'b0; prg_ld = 1'b0; sus_ld = 1'b0;
    set_e = 1'b0; set_p = 1'b0; set_l = 1'b0; clr_err = 1'b0;
    case (st)
      ST_IDLE, ST_ESUSP: if (fire) begin
        case (cmd_data)
          OP_ERASE:   if (st == ST_IDLE) st_n = ST_ERS_SET;
          OP_CONFIRM: if (st == ST_ESUSP) st_n = ST_ERASE;
          OP_PROG:    st_n = ST_PRG_SET;
          OP_LKSETUP: st_n = ST_LCK_SET;
          OP_CLRSR:   clr_err = 1'b1;
          default:    ;
        endcase
      end
      ST_ERS_SET: if (fire) begin
        st_n = ST_IDLE;
        if (cmd_data != OP_CONFIRM) begin set_e = 1'b1; set_p = 1'b1; end
        else if (cur_on)            begin set_e = 1'b1; set_l = 1'b1; end
        else                        begin ers_ld = 1'b1; st_n = ST_ERASE; end
      end
      ST_PRG_SET: if (fire) begin
        st_n = ers_act ? ST_ESUSP : ST_IDLE;
        if (cur_on)                             begin set_p = 1'b1; set_l = 1'b1; end
        else if (ers_act && cmd_blk == ers_blk) set_p = 1'b1;
        else                                    begin prg_ld = 1'b1; st_n = ST_PROG; end
      end
      ST_LCK_SET: if (fire) begin
        st_n = ers_act ? ST_ESUSP : ST_IDLE;
        case (cmd_data)
          OP_LOCK:    lkop = LK_LOCK;
          OP_CONFIRM: lkop = LK_UNLOCK;
          OP_LOCKDN:  lkop = LK_DOWN;
          default:    begin set_e = 1'b1; set_p = 1'b1; end
        endcase
      end
      ST_ERASE:
        if (ers_done) st_n = ST_IDLE;
        else if (fire && cmd_data == OP_SUSPEND) begin sus_ld = 1'b1; st_n = ST_SWAIT; end
      ST_PROG:
        if (prg_done) st_n = ers_act ? ST_ESUSP : ST_IDLE;
        else if (fire && cmd_data == OP_SUSPEND) begin sus_ld = 1'b1; st_n = ST_SWAIT; end
      ST_SWAIT:
        if (sus_done) st_n = prg_act ? ST_PSUSP : ST_ESUSP;
      ST_PSUSP:
        if (fire && cmd_data == OP_CONFIRM) st_n = ST_PROG;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ers_act <= 1'b0; prg_act <= 1'b0; ers_sus <= 1'b0; prg_sus <= 1'b0;
      err_e <= 1'b0; err_p <= 1'b0; err_l <= 1'b0;
      ers_blk <= '0;
    end else begin
      st <= st_n;
      if (ers_ld) begin ers_act <= 1'b1; ers_blk <= cmd_blk; end
      else if (ers_done) ers_act <= 1'b0;
      if (prg_ld) prg_act <= 1'b1;
      else if (prg_done) prg_act <= 1'b0;
      if (st == ST_SWAIT && st_n == ST_ESUSP) ers_sus <= 1'b1;
      else if (st == ST_ESUSP && st_n == ST_ERASE) ers_sus <= 1'b0;
      if (st == ST_SWAIT && st_n == ST_PSUSP) prg_sus <= 1'b1;
      else if (st == ST_PSUSP && st_n == ST_PROG) prg_sus <= 1'b0;
      if (clr_err) begin err_e <= 1'b0; err_p <= 1'b0; err_l <= 1'b0; end
      else begin
        if (set_e) err_e <= 1'b1;
        if (set_p) err_p <= 1'b1;
        if (set_l) err_l <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [7:0]      cmd_data,
  input logic [7:0]      status,
  input logic [NBLK-1:0] lk_on,
  input logic [NBLK-1:0] lk_dn
);
  logic clr_fire;
  assign clr_fire = cmd_valid && cmd_ready && (cmd_data == 8'h50);

  assert_sr5_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clr_fire) |=> status[5]);
  assert_sr4_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clr_fire) |=> status[4]);
  assert_susp_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> status[7]);
  assert_backpressure_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !status[7]);
  assert_down_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lk_dn) & ~lk_dn) == '0));
  assert_psusp_nolock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> $stable(lk_on));
endmodule

bind flash_cmd_ctrl fcmd_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .status(status), .lk_on(lk_on), .lk_dn(lk_dn));

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PER = 10;
  localparam int ERS = 20;
  localparam int PRG = 6;
  localparam int SUS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_data = '0;
  logic [2:0] cmd_blk = '0, rd_blk = '0;
  logic [7:0] status;
  logic [1:0] rd_lock;
  int nchk = 0, nfail = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_cmd_ctrl #(.NBLK(8), .ERS_CYC(ERS), .PRG_CYC(PRG), .SUS_LAT(SUS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_blk(cmd_blk), .status(status),
    .rd_blk(rd_blk), .rd_lock(rd_lock));

  typedef struct packed {
    logic [7:0] cmd; logic [2:0] blk; logic wt;
    logic [7:0] sr;  logic [1:0] lk;  logic [3:0] rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{8'h60,3'd1,1'b0,8'h80,2'b01,4'd4},  // R4 setup
    '{8'hD0,3'd1,1'b0,8'h80,2'b00,4'd4},  // R4 unlock
    '{8'h60,3'd2,1'b0,8'h80,2'b01,4'd4},
    '{8'hD0,3'd2,1'b0,8'h80,2'b00,4'd4},
    '{8'h20,3'd1,1'b0,8'h80,2'b00,4'd2},  // R2 erase setup
    '{8'hD0,3'd1,1'b0,8'h00,2'b00,4'd2},  // R2 erase busy
    '{8'hB0,3'd1,1'b0,8'h00,2'b00,4'd3},  // R3 suspend pending
    '{8'h50,3'd1,1'b1,8'hC0,2'b00,4'd3},  // R3 R13 accepted once suspended
    '{8'h60,3'd1,1'b0,8'hC0,2'b00,4'd7},
    '{8'h01,3'd1,1'b0,8'hC0,2'b01,4'd7},  // R7 lock suspended block
    '{8'h60,3'd3,1'b0,8'hC0,2'b01,4'd5},
    '{8'h55,3'd3,1'b0,8'hF0,2'b01,4'd5},  // R5 bad confirm
    '{8'hD0,3'd1,1'b1,8'hB0,2'b01,4'd6},  // R6 R7 resume, complete, sticky
    '{8'h50,3'd1,1'b1,8'h80,2'b01,4'd9},  // R9 clear
    '{8'h20,3'd2,1'b0,8'h80,2'b00,4'd2},
    '{8'hD0,3'd2,1'b0,8'h00,2'b00,4'd2},
    '{8'hB0,3'd2,1'b0,8'h00,2'b00,4'd3},
    '{8'h40,3'd0,1'b1,8'hC0,2'b01,4'd8},  // R8 program setup in suspend
    '{8'h33,3'd0,1'b1,8'hD2,2'b01,4'd8},  // R8 locked target
    '{8'hD0,3'd2,1'b1,8'h92,2'b00,4'd8},  // R8 R6 persists
    '{8'h50,3'd2,1'b1,8'h80,2'b00,4'd9},
    '{8'h60,3'd4,1'b0,8'h80,2'b01,4'd4},
    '{8'h2F,3'd4,1'b0,8'h80,2'b11,4'd4},  // R4 lock-down
    '{8'h60,3'd4,1'b0,8'h80,2'b11,4'd10},
    '{8'hD0,3'd4,1'b0,8'h80,2'b11,4'd10}, // R10 unlock ignored
    '{8'h20,3'd4,1'b0,8'h80,2'b11,4'd11},
    '{8'hD0,3'd4,1'b1,8'hA2,2'b11,4'd11}, // R11 locked erase
    '{8'h50,3'd4,1'b1,8'h80,2'b11,4'd9},
    '{8'h40,3'd2,1'b0,8'h80,2'b00,4'd12},
    '{8'h77,3'd2,1'b0,8'h00,2'b00,4'd12},
    '{8'hB0,3'd2,1'b0,8'h00,2'b00,4'd12},
    '{8'h60,3'd2,1'b1,8'h84,2'b00,4'd12}, // R12 ignored in program suspend
    '{8'h01,3'd2,1'b0,8'h84,2'b00,4'd12},
    '{8'hD0,3'd2,1'b1,8'h80,2'b00,4'd12}  // R12 resume completes
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic [2:0] b);
    rd_blk = b;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_data = c; cmd_blk = b;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rdy();
    int t = 0;
    while (!status[7] && t < 1000) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", {7'd0, cmd_ready, status}, {7'd0, 1'b1, 8'h80});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].cmd, VEC[i].blk);
      if (VEC[i].wt) wait_rdy();
      chk($sformatf("R%0d vec %0d", VEC[i].rq, i),
          {status, 6'd0, rd_lock}, {VEC[i].sr, 6'd0, VEC[i].lk});
    end

    // R2 exact erase duration
    apply(8'h60, 3'd5); apply(8'hD0, 3'd5);
    apply(8'h20, 3'd5); apply(8'hD0, 3'd5);
    repeat (ERS - 1) @(negedge clk);
    chk("R2 busy last cycle", {8'd0, status}, 16'h0000);
    @(negedge clk);
    chk("R2 ready after erase", {8'd0, status}, 16'h0080);

    // R3 exact suspend latency, R13 back-pressure
    apply(8'h20, 3'd5); apply(8'hD0, 3'd5);
    repeat (2) @(negedge clk);
    apply(8'hB0, 3'd5);
    repeat (SUS - 1) @(negedge clk);
    chk("R3 R13 still suspending", {7'd0, cmd_ready, status}, 16'h0000);
    @(negedge clk);
    chk("R3 R13 suspended", {7'd0, cmd_ready, status}, {7'd0, 1'b1, 8'hC0});
    apply(8'hD0, 3'd5);
    wait_rdy();
    chk("R2 resumed erase done", {8'd0, status}, 16'h0080);

    // R1 R10 reset restores default protection
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", {7'd0, cmd_ready, status}, {7'd0, 1'b1, 8'h80});
    for (int b = 0; b < 8; b++) begin
      rd_blk = 3'(b);
      #1;
      chk($sformatf("R1 R10 lock blk %0d", b), {14'd0, rd_lock}, 16'h0001);
    end
    finish_run();
  end
endmodule